// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit forms a physical memory address from a 16-bit offset and one of four programmable segment registers. The base of each segment is its register value shifted left by four bits. A segment can therefore start on any 16-byte boundary and covers a 64 KB window above that base. Two or more registers may hold the same or nearby values, so their windows can overlap fully or in part. The unit accepts this without complaint.

Each request names an access kind. Instruction fetches go through the code register and stack accesses through the stack register. Data accesses use the data register unless an override field picks one of the four registers. A register write port loads one register per cycle. The translated address comes out of a register stage one clock after the request, together with a valid bit and a flag. The flag is set when the sum ran past the top of the 1 MB space and wrapped around to the bottom.

Top module: `seg_agu`

## Requirements
- R1: Reset clears all four segment registers to zero and drives out_valid, out_addr and out_wrap to zero; a request right after reset returns its offset unchanged as the address.
- R2: out_valid is high in the cycle after a cycle with req_valid high, and low in the cycle after a cycle with req_valid low.
- R3: The result address equals (segment register value × 16 + offset) modulo 2^20.
- R4: out_wrap is 1 exactly when segment value × 16 + offset exceeds 0xFFFFF, so base 0xFFFF0 with offset 0x000F gives 0xFFFFF without wrap and offset 0x0010 gives 0x00000 with wrap.
- R5: A fetch (req_kind = 0) always uses register index 1 (code), whatever the override inputs are.
- R6: A stack access (req_kind = 1) always uses register index 2 (stack), whatever the override inputs are.
- R7: A data access (req_kind = 2) uses register index 3 (data) when req_ovr_en is 0, and register req_ovr_sel (0 extra, 1 code, 2 stack, 3 data) when req_ovr_en is 1.
- R8: A register write takes effect for requests in the following cycle. A request in the same cycle as a write to the register it uses sees the old value. A write in a cycle with no request still takes effect.
- R9: Registers holding equal values, or values whose windows overlap, give the same physical address for the same byte.
- R10: In a cycle after one with no request, out_addr and out_wrap keep their previous values.
- R11: req_kind = 3 behaves exactly like a data access, including the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one segment register this cycle |
| wr_sel | input | 2 | Register to write: 0 extra, 1 code, 2 stack, 3 data |
| wr_data | input | 16 | New segment register value |
| req_valid | input | 1 | Translation request present |
| req_kind | input | 2 | 0 fetch, 1 stack, 2 data, 3 data |
| req_ovr_en | input | 1 | Use req_ovr_sel for data accesses |
| req_ovr_sel | input | 2 | Override register index |
| req_offset | input | 16 | Offset inside the segment |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_addr | output | 20 | Physical address |
| out_wrap | output | 1 | Sum passed 0xFFFFF and wrapped |

## Verification
The properties assume that every input is a known 0 or 1 at each rising edge while reset is released. They also assume that a write and a request in the same cycle are ordered so that the request reads the register as it stood before that edge. The stimulus drives all inputs only on falling edges, keeps every input defined from time zero, and releases reset on a falling edge. Because of this, each request and each write falls into exactly one clock cycle.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    // Access kinds carried on req_kind.
    typedef enum logic [1:0] {
        ACC_FETCH    = 2'd0,
        ACC_STACK    = 2'd1,
        ACC_DATA     = 2'd2,
        ACC_DATA_ALT = 2'd3
    } acc_kind_e;

    // Segment register indices.
    localparam logic [1:0] SEG_EXTRA = 2'd0;
    localparam logic [1:0] SEG_CODE  = 2'd1;
    localparam logic [1:0] SEG_STACK = 2'd2;
    localparam logic [1:0] SEG_DATA  = 2'd3;

endpackage

// File: rtl/seg_agu_bank.sv
module seg_agu_bank #(
    parameter int NSEG  = 4,
    parameter int SEG_W = 16,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_data
);

    logic [SEG_W-1:0] seg_d [NSEG];
    logic [SEG_W-1:0] seg_q [NSEG];

    // Next state: each register takes the write data when addressed.
    for (genvar i = 0; i < NSEG; i++) begin : g_reg
        always_comb begin
            seg_d[i] = seg_q[i];
            if (wr_en && (wr_sel == SEL_W'(i))) begin
                seg_d[i] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[i] <= '0;
            end else begin
                seg_q[i] <= seg_d[i];
            end
        end
    end

    // Read returns the registered value, so a write in the same cycle
    // is not seen until the following one.
    assign rd_data = seg_q[rd_sel];

endmodule

// File: rtl/seg_agu_pick.sv
module seg_agu_pick
    import seg_agu_pkg::*;
#(
    parameter int NSEG = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic [1:0]       kind,
    input  logic             ovr_en,
    input  logic [SEL_W-1:0] ovr_sel,
    output logic [SEL_W-1:0] seg_idx
);

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_FETCH:    seg_idx = SEL_W'(SEG_CODE);
            ACC_STACK:    seg_idx = SEL_W'(SEG_STACK);
            ACC_DATA,
            ACC_DATA_ALT: seg_idx = ovr_en ? ovr_sel : SEL_W'(SEG_DATA);
            default:      seg_idx = SEL_W'(SEG_DATA);
        endcase
    end

endmodule

// File: rtl/seg_agu_sum.sv
module seg_agu_sum #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20,
    localparam int BASE_W = SEG_W + SHIFT,
    localparam int SUM_W  = ((BASE_W > OFS_W) ? BASE_W : OFS_W) + 1
) (
    input  logic [SEG_W-1:0] seg_val,
    input  logic [OFS_W-1:0] offset,
    output logic [PA_W-1:0]  addr,
    output logic             wrap
);

    logic [BASE_W-1:0] base;
    logic [SUM_W-1:0]  sum;

    assign base = {seg_val, {SHIFT{1'b0}}};
    assign sum  = SUM_W'(base) + SUM_W'(offset);
    assign addr = sum[PA_W-1:0];

    // Any bit above the physical width means the sum left the space.
    if (SUM_W > PA_W) begin : g_wrap
        assign wrap = |sum[SUM_W-1:PA_W];
    end else begin : g_nowrap
        assign wrap = 1'b0;
    end

endmodule

// File: rtl/seg_agu.sv
module seg_agu
    import seg_agu_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_ovr_en,
    input  logic [SEL_W-1:0] req_ovr_sel,
    input  logic [OFS_W-1:0] req_offset,
    output logic             out_valid,
    output logic [PA_W-1:0]  out_addr,
    output logic             out_wrap
);

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
        logic            wrap;
    } result_t;

    logic [SEL_W-1:0] seg_idx;
    logic [SEG_W-1:0] seg_val;
    logic [PA_W-1:0]  sum_addr;
    logic             sum_wrap;
    result_t          res_d;
    result_t          res_q;

    seg_agu_pick #(
        .NSEG (NSEG)
    ) u_pick (
        .kind    (req_kind),
        .ovr_en  (req_ovr_en),
        .ovr_sel (req_ovr_sel),
        .seg_idx (seg_idx)
    );

    seg_agu_bank #(
        .NSEG  (NSEG),
        .SEG_W (SEG_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (seg_idx),
        .rd_data (seg_val)
    );

    seg_agu_sum #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W),
        .SHIFT (SHIFT),
        .PA_W  (PA_W)
    ) u_sum (
        .seg_val (seg_val),
        .offset  (req_offset),
        .addr    (sum_addr),
        .wrap    (sum_wrap)
    );

    // Next result: capture on a request, otherwise hold address and flag.
    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.addr = sum_addr;
            res_d.wrap = sum_wrap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_addr  = res_q.addr;
    assign out_wrap  = res_q.wrap;

endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk
    import seg_agu_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20,
    localparam int SEL_W = $clog2(NSEG),
    localparam int WIDE  = SEG_W + SHIFT + OFS_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_sel,
    input logic [SEG_W-1:0] wr_data,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic             req_ovr_en,
    input logic [SEL_W-1:0] req_ovr_sel,
    input logic [OFS_W-1:0] req_offset,
    input logic             out_valid,
    input logic [PA_W-1:0]  out_addr,
    input logic             out_wrap
);

    // Independent shadow of the segment registers.
    logic [SEG_W-1:0] shadow [NSEG];
    logic [SEL_W-1:0] m_idx;
    logic [WIDE-1:0]  m_sum;
    logic [PA_W-1:0]  m_addr;
    logic             m_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) shadow[i] <= '0;
        end else if (wr_en) begin
            shadow[wr_sel] <= wr_data;
        end
    end

    always_comb begin
        if (req_kind == 2'd0)      m_idx = SEL_W'(SEG_CODE);
        else if (req_kind == 2'd1) m_idx = SEL_W'(SEG_STACK);
        else if (req_ovr_en)       m_idx = req_ovr_sel;
        else                       m_idx = SEL_W'(SEG_DATA);
        m_sum  = (WIDE'(shadow[m_idx]) << SHIFT) + WIDE'(req_offset);
        m_addr = m_sum[PA_W-1:0];
        m_wrap = (m_sum >> PA_W) != '0;
    end

    // R1: reset holds the result register cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_addr == '0 && !out_wrap));

    // R2: valid follows the request by one cycle.
    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R2: no request, no valid.
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R3 R5 R6 R7 R8 R11: address matches the shadow model.
    a_r3_addr_model: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_addr == $past(m_addr)));

    // R4: wrap flag matches the wide sum.
    a_r4_wrap_model: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_wrap == $past(m_wrap)));

    // R10: result holds when idle.
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_addr) && $stable(out_wrap)));

endmodule

bind seg_agu seg_agu_chk #(
    .NSEG  (NSEG),
    .SEG_W (SEG_W),
    .OFS_W (OFS_W),
    .SHIFT (SHIFT),
    .PA_W  (PA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_ovr_en  (req_ovr_en),
    .req_ovr_sel (req_ovr_sel),
    .req_offset  (req_offset),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_wrap    (out_wrap)
);

// File: tb/sim_seg_agu.sv
`timescale 1ns/1ps
module sim_seg_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_ovr_en = 1'b0;
    logic [1:0]  req_ovr_sel = '0;
    logic [15:0] req_offset = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic        out_wrap;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    seg_agu u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_ovr_en  (req_ovr_en),
        .req_ovr_sel (req_ovr_sel),
        .req_offset  (req_offset),
        .out_valid   (out_valid),
        .out_addr    (out_addr),
        .out_wrap    (out_wrap)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  ws;
        logic [15:0] wd;
        logic        rv;
        logic [1:0]  kd;
        logic        oe;
        logic [1:0]  os;
        logic [15:0] off;
        logic        ev;
        logic [19:0] ea;
        logic        ew;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    // Each row drives one cycle; its result is checked one clock later.
    localparam vec_t VECS [NV] = '{
        // R1 R3: registers zero after reset, fetch returns offset
        {1'b0,2'd0,16'h0000, 1'b1,2'd0,1'b0,2'd0,16'h0123, 1'b1,20'h00123,1'b0,4'd1},
        // R8: code written to 0x1000 while fetch in same cycle sees old zero
        {1'b1,2'd1,16'h1000, 1'b1,2'd0,1'b0,2'd0,16'h0010, 1'b1,20'h00010,1'b0,4'd8},
        // R5 R3: fetch now sees new code value
        {1'b0,2'd0,16'h0000, 1'b1,2'd0,1'b0,2'd0,16'h0010, 1'b1,20'h10010,1'b0,4'd5},
        // R7: data without override uses data register (still zero)
        {1'b1,2'd2,16'hFFFF, 1'b1,2'd2,1'b0,2'd0,16'h0005, 1'b1,20'h00005,1'b0,4'd7},
        // R4 R6: stack 0xFFFF0 + 0x10 wraps to zero
        {1'b0,2'd0,16'h0000, 1'b1,2'd1,1'b0,2'd0,16'h0010, 1'b1,20'h00000,1'b1,4'd4},
        // R4: top byte reached without wrap
        {1'b0,2'd0,16'h0000, 1'b1,2'd1,1'b0,2'd0,16'h000F, 1'b1,20'hFFFFF,1'b0,4'd4},
        // R5: fetch ignores override to stack
        {1'b1,2'd3,16'h1000, 1'b1,2'd0,1'b1,2'd2,16'h0020, 1'b1,20'h10020,1'b0,4'd5},
        // R9: data equals code, same byte as previous row
        {1'b0,2'd0,16'h0000, 1'b1,2'd2,1'b0,2'd0,16'h0020, 1'b1,20'h10020,1'b0,4'd9},
        // R8 R7: extra written, override to extra sees old zero
        {1'b1,2'd0,16'h1001, 1'b1,2'd2,1'b1,2'd0,16'h0000, 1'b1,20'h00000,1'b0,4'd8},
        // R9: extra 0x1001 overlaps code 0x1000 at offset 0x10
        {1'b0,2'd0,16'h0000, 1'b1,2'd2,1'b1,2'd0,16'h0000, 1'b1,20'h10010,1'b0,4'd9},
        // R6: stack ignores override to code
        {1'b0,2'd0,16'h0000, 1'b1,2'd1,1'b1,2'd1,16'h0001, 1'b1,20'hFFFF1,1'b0,4'd6},
        // R11: kind 3 without override uses data
        {1'b0,2'd0,16'h0000, 1'b1,2'd3,1'b0,2'd0,16'h0100, 1'b1,20'h10100,1'b0,4'd11},
        // R10 R2: idle, valid drops, result held
        {1'b0,2'd0,16'h0000, 1'b0,2'd0,1'b0,2'd0,16'h0000, 1'b0,20'h10100,1'b0,4'd10},
        // R4 R7: override to stack, max offset, wraps
        {1'b0,2'd0,16'h0000, 1'b1,2'd2,1'b1,2'd2,16'hFFFF, 1'b1,20'h0FFEF,1'b1,4'd4},
        // R10: wrap flag held while idle
        {1'b0,2'd0,16'h0000, 1'b0,2'd1,1'b1,2'd3,16'h7777, 1'b0,20'h0FFEF,1'b1,4'd10},
        // R8: write during idle cycle, result still held
        {1'b1,2'd1,16'h0000, 1'b0,2'd0,1'b0,2'd0,16'h0000, 1'b0,20'h0FFEF,1'b1,4'd10},
        // R8: write from idle cycle took effect
        {1'b0,2'd0,16'h0000, 1'b1,2'd0,1'b0,2'd0,16'hABCD, 1'b1,20'h0ABCD,1'b0,4'd8},
        // R11: kind 3 honours override to stack
        {1'b0,2'd0,16'h0000, 1'b1,2'd3,1'b1,2'd2,16'h0003, 1'b1,20'hFFFF3,1'b0,4'd11}
    };

    task automatic check(input string tag, input logic ev,
                         input logic [19:0] ea, input logic ew);
        n_chk++;
        if (out_valid !== ev || out_addr !== ea || out_wrap !== ew) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b addr=%05h wrap=%0b, expected valid=%0b addr=%05h wrap=%0b",
                     tag, out_valid, out_addr, out_wrap, ev, ea, ew);
        end
    endtask

    task automatic drive(input vec_t v);
        wr_en       = v.we;
        wr_sel      = v.ws;
        wr_data     = v.wd;
        req_valid   = v.rv;
        req_kind    = v.kd;
        req_ovr_en  = v.oe;
        req_ovr_sel = v.os;
        req_offset  = v.off;
    endtask

    task automatic idle();
        drive('0);
    endtask

    initial begin
        #2 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b0, 20'h00000, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R%0d row %0d", VECS[i].rq, i),
                  VECS[i].ev, VECS[i].ea, VECS[i].ew);
        end

        // R1: reset in mid-run clears outputs and all registers.
        drive({1'b1,2'd3,16'h2222, 1'b1,2'd2,1'b0,2'd0,16'h0001, 1'b0,20'h0,1'b0,4'd0});
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 1'b0, 20'h00000, 1'b0);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            drive({1'b0,2'd0,16'h0000, 1'b1,2'd2,1'b1,2'(s),16'h0042, 1'b0,20'h0,1'b0,4'd0});
            @(negedge clk);
            check($sformatf("R1 register %0d zero after reset", s), 1'b1, 20'h00042, 1'b0);
        end

        // R2: valid falls one cycle after requests stop.
        idle();
        @(negedge clk);
        check("R2 valid low when idle", 1'b0, 20'h00042, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule